// File: doc/BRIEF.md
# Multi-Mode Memory-Mapped I/O Port

This block is an eight-pin general-purpose port that a processor reaches through a four-word register window. Each pin is served by one of three sources: the processor's own registers (CPU I/O), external programmable logic, or one bit of the latched system address. Software picks between CPU I/O and address output with a per-pin control bit. Build-time masks reserve pins for programmable logic, either as logic-driven outputs or as logic inputs.

The register window has four offsets:

- Offset 0 is the synchronized pad input and is read-only.
- Offset 1 is the per-pin control register.
- Offset 2 is the direction register.
- Offset 3 is the output data register.

A build-time switch can leave out the control register. The port then runs every pin that is not reserved for logic in CPU I/O mode.

Each pin comes out as a pad triple: output value, output enable and input level. Reads are combinational from the bus offset. Writes take effect on the rising clock edge when select and write are both high.

Top module: `mmio_port`

## Requirements
- R1: After reset the control, direction and output data registers read 0, and every pin's pad output enable is 0.
- R2: When `bus_sel` and `bus_wr` are both 1 at a rising edge, the register at `bus_addr` 1 (control), 2 (direction) or 3 (output data) takes `bus_wdata`. A read at that offset returns the new value from the next cycle on.
- R3: A write to offset 0 changes no register.
- R4: A pin in CPU I/O mode (control bit 0, not reserved for logic) whose direction bit is 1 drives `pad_out` from its output data bit, with `pad_oe` 1.
- R5: A CPU I/O pin whose direction bit is 0 has `pad_oe` 0.
- R6: A read at offset 0 returns `pad_in` through a two-flop synchronizer. A level applied before rising edge k is visible after edge k+1 and not after edge k alone.
- R7: A pin not reserved for logic whose control bit is 1 is in address mode: `pad_out` equals `addr_bits` of the same index and `pad_oe` is 1.
- R8: A pin in `LOGIC_DRV_MASK` (default 8'h30) follows `logic_out` and `logic_oe` for that index, whatever its control and direction bits hold.
- R9: A pin in `LOGIC_IN_MASK` (default 8'hC0) always has `pad_oe` 0 and `pad_out` 0, whatever its control and direction bits hold. If a pin is in both masks, it is treated as a logic input.
- R10: `logic_in` carries the synchronized pad level on pins in either logic mask and 0 on all other pins.
- R11: With `HAS_CTRL` = 0, offset 1 reads 0, writes to it are ignored, and no pin enters address mode.
- R12: No register changes in a cycle where `bus_sel` or `bus_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register window select |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` |
| addr_bits | input | 8 | Latched address bits that address-mode pins drive |
| logic_out | input | 8 | Output values from programmable logic |
| logic_oe | input | 8 | Output enables from programmable logic |
| logic_in | output | 8 | Synchronized pad levels for logic-reserved pins |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
On every cycle the assertions check the following:

- Idle cycles and writes to the read-only offset leave all three registers alone.
- Direction and output data writes land one edge later.
- The synchronizer's second stage trails its first by one edge.
- Logic-input pins are never enabled.
- Address-mode pins are always enabled.

Only the bench's scenarios can show the rest, which depends on the sources a pin picks:

- Each pin follows the right source under mixed random traffic.
- The visible latency from pad change to read value.
- The masking of `logic_in`.
- The behaviour of a second instance built without the control register.

// File: rtl/mmio_port_pkg.sv
package mmio_port_pkg;

  localparam int OFF_W = 2;

  localparam logic [OFF_W-1:0] OFF_PAD_IN = 2'd0;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 2'd1;
  localparam logic [OFF_W-1:0] OFF_DIR    = 2'd2;
  localparam logic [OFF_W-1:0] OFF_DOUT   = 2'd3;

  typedef enum logic [1:0] {
    MODE_CPU      = 2'd0,
    MODE_LOGIC_DR = 2'd1,
    MODE_LOGIC_IN = 2'd2,
    MODE_ADDR     = 2'd3
  } pin_mode_e;

  // Priority: logic input reservation, then logic drive, then control bit.
  function automatic pin_mode_e pick_mode(input logic ctrl_bit,
                                          input logic drv_rsv,
                                          input logic in_rsv);
    if (in_rsv)        return MODE_LOGIC_IN;
    else if (drv_rsv)  return MODE_LOGIC_DR;
    else if (ctrl_bit) return MODE_ADDR;
    else               return MODE_CPU;
  endfunction

  function automatic logic write_hits(input logic sel, input logic wr,
                                      input logic [OFF_W-1:0] off,
                                      input logic [OFF_W-1:0] target);
    return sel && wr && (off == target);
  endfunction

endpackage

// File: rtl/mmio_port_sync.sv
module mmio_port_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] stage1,
  output logic [WIDTH-1:0] stage2
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= async_in;
      stage2 <= stage1;
    end
  end

endmodule

// File: rtl/mmio_port_regs.sv
module mmio_port_regs
  import mmio_port_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit HAS_CTRL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [OFF_W-1:0] bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic [WIDTH-1:0] din_sync,
  output logic [WIDTH-1:0] bus_rdata,
  output logic [WIDTH-1:0] ctrl_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] dout_q,
  output logic             wr_fire
);

  logic hit_ctrl, hit_dir, hit_dout;

  assign wr_fire  = bus_sel && bus_wr;
  assign hit_ctrl = write_hits(bus_sel, bus_wr, bus_addr, OFF_CTRL);
  assign hit_dir  = write_hits(bus_sel, bus_wr, bus_addr, OFF_DIR);
  assign hit_dout = write_hits(bus_sel, bus_wr, bus_addr, OFF_DOUT);

  generate
    if (HAS_CTRL) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (hit_ctrl) ctrl_q <= bus_wdata;
      end
    end else begin : g_no_ctrl
      logic unused_hit;
      assign unused_hit = hit_ctrl;
      assign ctrl_q = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
    end else begin
      if (hit_dir)  dir_q  <= bus_wdata;
      if (hit_dout) dout_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_PAD_IN: bus_rdata = din_sync;
      OFF_CTRL:   bus_rdata = ctrl_q;
      OFF_DIR:    bus_rdata = dir_q;
      default:    bus_rdata = dout_q;
    endcase
  end

endmodule

// File: rtl/mmio_port_pinmux.sv
module mmio_port_pinmux
  import mmio_port_pkg::*;
#(
  parameter int               WIDTH          = 8,
  parameter logic [WIDTH-1:0] LOGIC_DRV_MASK = 8'h30,
  parameter logic [WIDTH-1:0] LOGIC_IN_MASK  = 8'hC0
) (
  input  logic [WIDTH-1:0] ctrl_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] dout_q,
  input  logic [WIDTH-1:0] addr_bits,
  input  logic [WIDTH-1:0] logic_out,
  input  logic [WIDTH-1:0] logic_oe,
  input  logic [WIDTH-1:0] din_sync,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] logic_in,
  output logic [WIDTH-1:0] addr_mode_vec
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pin_mode_e mode;
    assign mode = pick_mode(ctrl_q[i], LOGIC_DRV_MASK[i], LOGIC_IN_MASK[i]);

    always_comb begin
      case (mode)
        MODE_CPU: begin
          pad_out[i] = dout_q[i];
          pad_oe[i]  = dir_q[i];
        end
        MODE_LOGIC_DR: begin
          pad_out[i] = logic_out[i];
          pad_oe[i]  = logic_oe[i];
        end
        MODE_ADDR: begin
          pad_out[i] = addr_bits[i];
          pad_oe[i]  = 1'b1;
        end
        default: begin
          pad_out[i] = 1'b0;
          pad_oe[i]  = 1'b0;
        end
      endcase
    end

    assign logic_in[i] = din_sync[i] &&
                         (mode == MODE_LOGIC_DR || mode == MODE_LOGIC_IN);
    assign addr_mode_vec[i] = (mode == MODE_ADDR);
  end

endmodule

// File: rtl/mmio_port.sv
module mmio_port
  import mmio_port_pkg::*;
#(
  parameter int               WIDTH          = 8,
  parameter bit               HAS_CTRL       = 1'b1,
  parameter logic [WIDTH-1:0] LOGIC_DRV_MASK = 8'h30,
  parameter logic [WIDTH-1:0] LOGIC_IN_MASK  = 8'hC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] addr_bits,
  input  logic [WIDTH-1:0] logic_out,
  input  logic [WIDTH-1:0] logic_oe,
  output logic [WIDTH-1:0] logic_in,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);

  // Internal events brought out by name for the bound checker.
  logic [WIDTH-1:0] din_stage1;
  logic [WIDTH-1:0] din_sync;
  logic [WIDTH-1:0] ctrl_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] dout_q;
  logic [WIDTH-1:0] addr_mode_vec;
  logic             wr_fire;

  mmio_port_sync #(.WIDTH(WIDTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .stage1   (din_stage1),
    .stage2   (din_sync)
  );

  mmio_port_regs #(.WIDTH(WIDTH), .HAS_CTRL(HAS_CTRL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .din_sync  (din_sync),
    .bus_rdata (bus_rdata),
    .ctrl_q    (ctrl_q),
    .dir_q     (dir_q),
    .dout_q    (dout_q),
    .wr_fire   (wr_fire)
  );

  mmio_port_pinmux #(
    .WIDTH          (WIDTH),
    .LOGIC_DRV_MASK (LOGIC_DRV_MASK),
    .LOGIC_IN_MASK  (LOGIC_IN_MASK)
  ) u_mux (
    .ctrl_q        (ctrl_q),
    .dir_q         (dir_q),
    .dout_q        (dout_q),
    .addr_bits     (addr_bits),
    .logic_out     (logic_out),
    .logic_oe      (logic_oe),
    .din_sync      (din_sync),
    .pad_out       (pad_out),
    .pad_oe        (pad_oe),
    .logic_in      (logic_in),
    .addr_mode_vec (addr_mode_vec)
  );

endmodule

// File: rtl/mmio_port_chk.sv
module mmio_port_chk #(
  parameter int               WIDTH         = 8,
  parameter bit               HAS_CTRL      = 1'b1,
  parameter logic [WIDTH-1:0] LOGIC_IN_MASK = 8'hC0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] ctrl_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] dout_q,
  input logic [WIDTH-1:0] din_stage1,
  input logic [WIDTH-1:0] din_sync,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] addr_mode_vec
);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ($stable(ctrl_q) && $stable(dir_q) && $stable(dout_q))); // R12

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd0) |=> ($stable(ctrl_q) && $stable(dir_q) && $stable(dout_q))); // R3

  AST_DIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd2) |=> (dir_q == $past(bus_wdata))); // R2

  AST_DOUT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd3) |=> (dout_q == $past(bus_wdata))); // R2

  AST_SYNC_SECOND_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    din_sync == $past(din_stage1)); // R6

  AST_LOGIC_IN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & LOGIC_IN_MASK) == '0); // R9

  AST_ADDR_PIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mode_vec & ~pad_oe) == '0); // R7

  AST_NO_CTRL_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_CTRL == 1'b0) |-> (ctrl_q == '0 && addr_mode_vec == '0)); // R11

endmodule

bind mmio_port mmio_port_chk #(
  .WIDTH         (WIDTH),
  .HAS_CTRL      (HAS_CTRL),
  .LOGIC_IN_MASK (LOGIC_IN_MASK)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_sel       (bus_sel),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .ctrl_q        (ctrl_q),
  .dir_q         (dir_q),
  .dout_q        (dout_q),
  .din_stage1    (din_stage1),
  .din_sync      (din_sync),
  .pad_oe        (pad_oe),
  .addr_mode_vec (addr_mode_vec)
);

// File: tb/tb_mmio_port.sv
module tb_mmio_port;
  localparam int         CLK_PERIOD = 10;
  localparam logic [7:0] LDRV = 8'h30;
  localparam logic [7:0] LIN  = 8'hC0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = '0, addr_bits = '0, logic_out = '0, logic_oe = '0, pad_in = '0;
  logic [7:0] rdata_a, pout_a, poe_a, lin_a;
  logic [7:0] rdata_b, pout_b, poe_b, lin_b;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] sh_ctrl = '0, sh_dir = '0, sh_dout = '0;
  logic [7:0] nc_dir = '0, nc_dout = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_port #(.WIDTH(8), .HAS_CTRL(1'b1), .LOGIC_DRV_MASK(LDRV), .LOGIC_IN_MASK(LIN)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .addr_bits(addr_bits), .logic_out(logic_out),
    .logic_oe(logic_oe), .logic_in(lin_a), .pad_in(pad_in), .pad_out(pout_a), .pad_oe(poe_a));

  mmio_port #(.WIDTH(8), .HAS_CTRL(1'b0), .LOGIC_DRV_MASK(LDRV), .LOGIC_IN_MASK(LIN)) dut_noctl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .addr_bits(addr_bits), .logic_out(logic_out),
    .logic_oe(logic_oe), .logic_in(lin_b), .pad_in(pad_in), .pad_out(pout_b), .pad_oe(poe_b));

  // Expected pad {oe, out} vectors from the requirements' source rules.
  function automatic logic [15:0] exp_pads(input logic [7:0] c, input logic [7:0] d,
                                           input logic [7:0] o);
    logic [7:0] eo, ee;
    for (int i = 0; i < 8; i++) begin
      if (LIN[i])       begin eo[i] = 1'b0;         ee[i] = 1'b0;        end
      else if (LDRV[i]) begin eo[i] = logic_out[i]; ee[i] = logic_oe[i]; end
      else if (c[i])    begin eo[i] = addr_bits[i]; ee[i] = 1'b1;        end
      else              begin eo[i] = o[i];         ee[i] = d[i];        end
    end
    return {ee, eo};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Called just after a negedge; the write lands at the next posedge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (a == 2'd1) sh_ctrl = d;
    if (a == 2'd2) begin sh_dir = d; nc_dir = d; end
    if (a == 2'd3) begin sh_dout = d; nc_dout = d; end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] va, output logic [7:0] vb);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    va = rdata_a; vb = rdata_b;
    bus_sel = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] va, vb;
    logic [31:0] seed_val;
    seed_val = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int a = 1; a < 4; a++) begin
      rd(a[1:0], va, vb);
      check("R1 reg reset", {8'h0, va}, 16'h0);
    end
    check("R1 pad_oe reset", {8'h0, poe_a}, 16'h0);

    // R2/R4: direction and data out, CPU pins
    wr(2'd2, 8'hFF); wr(2'd3, 8'hA5);
    rd(2'd3, va, vb); check("R2 dout readback", {8'h0, va}, 16'h00A5);
    rd(2'd2, va, vb); check("R2 dir readback", {8'h0, va}, 16'h00FF);
    logic_oe = 8'h00; logic_out = 8'h00;
    #1 check("R4 cpu output pins", {poe_a, pout_a} & 16'h0F0F, 16'h0F05);

    // R3: write to read-only offset
    wr(2'd0, 8'h5A);
    rd(2'd3, va, vb); check("R3 ro write dout", {8'h0, va}, 16'h00A5);
    rd(2'd2, va, vb); check("R3 ro write dir", {8'h0, va}, 16'h00FF);
    rd(2'd1, va, vb); check("R3 ro write ctrl", {8'h0, va}, 16'h0000);

    // R12: strobe without select, select without strobe
    bus_sel = 0; bus_wr = 1; bus_addr = 2'd3; bus_wdata = 8'h11; @(negedge clk);
    bus_sel = 1; bus_wr = 0; @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    rd(2'd3, va, vb); check("R12 no write", {8'h0, va}, 16'h00A5);

    // R5: inputs undriven
    wr(2'd2, 8'h00);
    #1 check("R5 cpu inputs oe", {8'h0, poe_a & 8'h0F}, 16'h0000);

    // R7: address mode
    addr_bits = 8'hC9; wr(2'd1, 8'h0F);
    #1 check("R7 addr mode", {poe_a, pout_a} & 16'h0F0F, 16'h0F09);

    // R8 / R9: logic-reserved pins ignore ctrl and dir
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    logic_out = 8'hFF; logic_oe = 8'hEF;
    #1 check("R8 logic drive pins", {poe_a, pout_a} & 16'h3030, 16'h2030);
    check("R9 logic input pins", {poe_a, pout_a} & 16'hC0C0, 16'h0000);

    // R6 / R10: synchronizer latency and logic_in masking
    pad_in = 8'h00; repeat (3) @(negedge clk);
    pad_in = 8'h3C;
    @(negedge clk);
    rd(2'd0, va, vb); check("R6 one edge old", {8'h0, va}, 16'h0000);
    @(negedge clk);
    rd(2'd0, va, vb); check("R6 two edges new", {8'h0, va}, 16'h003C);
    check("R10 logic_in mask", {8'h0, lin_a}, 16'h0030);

    // R11: instance without control register
    wr(2'd1, 8'h0F);
    rd(2'd1, va, vb); check("R11 ctrl reads zero", {8'h0, vb}, 16'h0000);
    wr(2'd2, 8'h0F); wr(2'd3, 8'h0A); addr_bits = 8'h05;
    #1 check("R11 no addr mode", {poe_b, pout_b} & 16'h0F0F, 16'h0F0A);

    // Random traffic against the model, both instances.
    for (int n = 0; n < 600; n++) begin
      logic [7:0] e_ctrl, e_dir, e_dout, ec_dir, ec_dout;
      bus_sel   = $urandom_range(0, 3) != 0;
      bus_wr    = $urandom_range(0, 1);
      bus_addr  = 2'($urandom_range(0, 3));
      bus_wdata = 8'($urandom);
      addr_bits = 8'($urandom);
      logic_out = 8'($urandom);
      logic_oe  = 8'($urandom);
      pad_in    = 8'($urandom);
      e_ctrl = sh_ctrl; e_dir = sh_dir; e_dout = sh_dout;
      ec_dir = nc_dir;  ec_dout = nc_dout;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          2'd1: e_ctrl = bus_wdata;
          2'd2: begin e_dir = bus_wdata; ec_dir = bus_wdata; end
          2'd3: begin e_dout = bus_wdata; ec_dout = bus_wdata; end
          default: ;
        endcase
      end
      @(posedge clk); #1;
      sh_ctrl = e_ctrl; sh_dir = e_dir; sh_dout = e_dout;
      nc_dir = ec_dir; nc_dout = ec_dout;
      check("R4 R5 R7 R8 R9 random pads", {poe_a, pout_a}, exp_pads(sh_ctrl, sh_dir, sh_dout));
      check("R11 random pads no ctrl", {poe_b, pout_b}, exp_pads(8'h00, nc_dir, nc_dout));
      if (bus_addr != 2'd0) begin
        case (bus_addr)
          2'd1:    check("R2 random readback", {8'h0, rdata_a}, {8'h0, sh_ctrl});
          2'd2:    check("R2 random readback", {8'h0, rdata_a}, {8'h0, sh_dir});
          default: check("R2 random readback", {8'h0, rdata_a}, {8'h0, sh_dout});
        endcase
      end
      @(negedge clk);
    end
    bus_sel = 0; bus_wr = 0;
    finish_run();
  end
endmodule